// File: doc/BRIEF.md
# Distributed-Arithmetic Inner-Product Unit

This block forms a four-tap inner product, y = w0·x(k) + w1·x(k-1) + w2·x(k-2) + w3·x(k-3), and uses no multiplier. A delay line holds the newest sample and the three before it. Each time a sample is accepted, a table of partial sums is rebuilt. The table has one entry for every subset of the four held samples. The weights do not enter as whole words. They arrive as a stream of 4-bit slices: slice bit j is one bit of weight wj. Each slice addresses the table, and the selected partial sum is folded into a carry-save accumulator. The carry and sum words are added together only once, after the last slice.

A run begins with a one-cycle start pulse while the sequencer is in IDLE. The sequencer then moves to ACCUM and takes exactly L slices on L consecutive clock edges, L being the weight word length. After the last slice it moves to RESOLVE for one cycle. In RESOLVE the two carry-save words are added, and the block registers the result and raises a done flag. It then returns to IDLE. The transitions are IDLE→ACCUM on start, ACCUM→ACCUM while slices remain, ACCUM→RESOLVE on the last slice, and RESOLVE→IDLE always. The weights are two's complement, and the slice order is chosen per run. Sample updates are meant for the IDLE state, between runs.

Top module: `da_inner_prod`

## Requirements
- R1: Each cycle with `samp_vld` high shifts the delay line. The new `samp_in` becomes x(k), and the old x(k), x(k-1) and x(k-2) become x(k-1), x(k-2) and x(k-3).
- R2: A slice with value s reads the sum of every held sample x(k-j) whose bit j of s is 1. Bit 0 selects x(k) and bit 3 selects x(k-3). The all-zero slice contributes exactly zero.
- R3: The completed result equals the exact sum of wj·x(k-j) over the four taps. Each wj is an L-bit two's-complement integer, and its top bit carries weight −2^(L−1).
- R4: With `lsb_first` low at start, the slices arrive top bit first: weight bit L−1 in the first ACCUM cycle, down to bit 0 in the last.
- R5: With `lsb_first` high at start, the slices arrive bit 0 first, up to bit L−1 in the last ACCUM cycle. The order is captured at start and holds for the whole run.
- R6: A start sampled in IDLE puts the slices in the L cycles that follow. The result and `y_done` appear on the clock edge one cycle after the edge that takes the last slice.
- R7: `y_done` is high for exactly one cycle per run, and `y_out` changes only on the edge that raises `y_done`.
- R8: A start pulse that arrives during ACCUM or RESOLVE is ignored. It neither restarts the count nor produces an extra result.
- R9: `y_out` is the result sign-extended to the full output width, for both negative and positive results at the range limits.
- R10: While reset is held, `y_out` is zero and `y_done` is low.
- R11: A sample accepted between two runs rebuilds the partial sums, so the next run uses the updated delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_in | input | DW | Two's-complement input sample |
| samp_vld | input | 1 | Accept `samp_in` into the delay line |
| slice_in | input | NTAP | One bit of each weight; bit j belongs to tap j |
| lsb_first | input | 1 | Slice order for the run starting now (1 = bit 0 first) |
| start | input | 1 | Begin a run (only honoured in IDLE) |
| y_out | output | OUT_W | Signed inner product, sign-extended |
| y_done | output | 1 | One-cycle pulse when `y_out` is updated |

## Verification
The bench drives the most negative weights against the most negative samples, which gives the largest positive product. It also drives the largest positive weight against the most negative sample. A design that adds the top-bit partial sum instead of subtracting it, or that drops the sign extension, returns a wrong magnitude or sign in these runs. One-hot weights are applied after known sample pushes. These runs catch a table that is wired to the wrong tap, a table that is not rebuilt when a sample arrives, or an all-zero slice that reads a stale entry. The same weights are run in both slice orders, so reversed slice handling shows up as a mismatch. A start pulse is injected mid-run. A design that restarted on it would move `y_done` away from the cycle the reference model predicts.

// File: rtl/da_pkg.sv
package da_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_RESOLVE
    } da_state_e;

endpackage

// File: rtl/da_tap_table.sv
module da_tap_table #(
    parameter int NTAP = 4,
    parameter int DW   = 8,
    parameter int TW   = DW + $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_vld,
    input  logic [DW-1:0]        samp_in,
    input  logic [NTAP-1:0]      sel,
    output logic signed [TW-1:0] pp
);
    localparam int NENT = 1 << NTAP;

    logic signed [DW-1:0] dly   [NTAP];
    logic signed [DW-1:0] dly_n [NTAP];
    logic signed [TW-1:0] ent_rd [NENT];

    // Delay-line contents after the pending shift
    always_comb begin
        dly_n[0] = samp_in;
        for (int j = 1; j < NTAP; j++) begin
            dly_n[j] = dly[j-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NTAP; j++) dly[j] <= '0;
        end else if (samp_vld) begin
            for (int j = 0; j < NTAP; j++) dly[j] <= dly_n[j];
        end
    end

    // The empty subset is a constant and takes no storage
    assign ent_rd[0] = '0;

    for (genvar e = 1; e < NENT; e++) begin : g_ent
        logic signed [TW-1:0] ent_q;
        logic signed [TW-1:0] ent_d;

        always_comb begin
            ent_d = '0;
            for (int j = 0; j < NTAP; j++) begin
                if (((e >> j) & 1) != 0) begin
                    ent_d = ent_d + {{(TW-DW){dly_n[j][DW-1]}}, dly_n[j]};
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        ent_q <= '0;
            else if (samp_vld) ent_q <= ent_d;
        end

        assign ent_rd[e] = ent_q;
    end

    assign pp = ent_rd[sel];

endmodule

// File: rtl/da_csa_acc.sv
module da_csa_acc #(
    parameter int TW = 10,
    parameter int AW = 18,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 lsb,
    input  logic                 neg,
    input  logic [CW-1:0]        cnt,
    input  logic signed [TW-1:0] pp,
    output logic [AW-1:0]        total
);
    logic [AW-1:0] sum_q, car_q;
    logic [AW-1:0] s_b, c_b, t_ext, t_sh, term, s_n, c_n, maj;

    always_comb begin
        // Top-bit-first doubles the running value; bit-0-first weights the term
        s_b   = lsb ? sum_q : (sum_q << 1);
        c_b   = lsb ? car_q : (car_q << 1);
        t_ext = {{(AW-TW){pp[TW-1]}}, pp};
        t_sh  = lsb ? (t_ext << cnt) : t_ext;
        // Subtraction: invert here, the +1 rides in the free carry LSB
        term  = neg ? ~t_sh : t_sh;
        s_n   = s_b ^ c_b ^ term;
        maj   = (s_b & c_b) | (s_b & term) | (c_b & term);
        c_n   = {maj[AW-2:0], neg};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
            car_q <= '0;
        end else if (en) begin
            sum_q <= s_n;
            car_q <= c_n;
        end
    end

    // Single carry-propagate add, consumed only in RESOLVE
    assign total = sum_q + car_q;

endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
    import da_pkg::*;
#(
    parameter int WL = 8,
    parameter int CW = $clog2(WL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          lsb_first,
    output da_state_e     st,
    output logic [CW-1:0] cnt,
    output logic          lsb_q,
    output logic          acc_clr,
    output logic          acc_en,
    output logic          neg,
    output logic          resolve
);
    localparam logic [CW-1:0] LAST = CW'(WL - 1);

    da_state_e st_n;

    // State register, slice counter and captured order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            lsb_q <= 1'b0;
        end else begin
            st <= st_n;
            if (st == ST_IDLE && start) begin
                cnt   <= '0;
                lsb_q <= lsb_first;
            end else if (st == ST_ACCUM) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:    if (start) st_n = ST_ACCUM;
            ST_ACCUM:   if (cnt == LAST) st_n = ST_RESOLVE;
            ST_RESOLVE: st_n = ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_clr = (st == ST_IDLE) && start;
        acc_en  = (st == ST_ACCUM);
        neg     = acc_en && (lsb_q ? (cnt == LAST) : (cnt == '0));
        resolve = (st == ST_RESOLVE);
    end

endmodule

// File: rtl/da_inner_prod.sv
module da_inner_prod
    import da_pkg::*;
#(
    parameter int DW    = 8,
    parameter int WL    = 8,
    parameter int NTAP  = 4,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    samp_in,
    input  logic             samp_vld,
    input  logic [NTAP-1:0]  slice_in,
    input  logic             lsb_first,
    input  logic             start,
    output logic [OUT_W-1:0] y_out,
    output logic             y_done
);
    localparam int TW = DW + $clog2(NTAP);
    localparam int AW = TW + WL;
    localparam int CW = $clog2(WL);

    da_state_e            st;
    logic [CW-1:0]        cnt;
    logic                 lsb_q, acc_clr, acc_en, neg, resolve;
    logic signed [TW-1:0] pp;
    logic [AW-1:0]        total;

    da_ctrl #(.WL(WL), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .lsb_first(lsb_first),
        .st(st), .cnt(cnt), .lsb_q(lsb_q), .acc_clr(acc_clr),
        .acc_en(acc_en), .neg(neg), .resolve(resolve)
    );

    da_tap_table #(.NTAP(NTAP), .DW(DW), .TW(TW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_in(samp_in),
        .sel(slice_in), .pp(pp)
    );

    da_csa_acc #(.TW(TW), .AW(AW), .CW(CW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en), .lsb(lsb_q),
        .neg(neg), .cnt(cnt), .pp(pp), .total(total)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out  <= '0;
            y_done <= 1'b0;
        end else begin
            y_done <= resolve;
            if (resolve) y_out <= {{(OUT_W-AW){total[AW-1]}}, total};
        end
    end

endmodule

// File: rtl/da_inner_prod_chk.sv
module da_inner_prod_chk
    import da_pkg::*;
#(
    parameter int WL    = 8,
    parameter int OUT_W = 24,
    parameter int AW    = 18,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OUT_W-1:0] y_out,
    input logic             y_done,
    input da_state_e        st,
    input logic [CW-1:0]    cnt
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_done |=> !y_done);

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_done |-> $stable(y_out));

    // R9
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_done |-> ($countones(y_out[OUT_W-1:AW-1]) == 0 ||
                    $countones(y_out[OUT_W-1:AW-1]) == OUT_W - AW + 1));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCUM && start && cnt != CW'(WL - 1)) |=> (st == ST_ACCUM));

    // R6
    accum_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCUM && cnt == CW'(WL - 1)) |=> (st == ST_RESOLVE));

    // R6
    resolve_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESOLVE) |=> y_done);

endmodule

bind da_inner_prod da_inner_prod_chk #(
    .WL(WL), .OUT_W(OUT_W), .AW(AW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .y_out(y_out),
    .y_done(y_done), .st(st), .cnt(cnt)
);

// File: tb/sim_da_inner_prod.sv
`timescale 1ns/1ps
module sim_da_inner_prod;
    localparam int DW = 8, WL = 8, NTAP = 4, OUT_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DW-1:0]    samp_in = '0;
    logic             samp_vld = 1'b0;
    logic [NTAP-1:0]  slice_in = '0;
    logic             lsb_first = 1'b0;
    logic             start = 1'b0;
    logic [OUT_W-1:0] y_out;
    logic             y_done;

    always #2.5 clk = ~clk;

    da_inner_prod #(.DW(DW), .WL(WL), .NTAP(NTAP), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .samp_vld(samp_vld),
        .slice_in(slice_in), .lsb_first(lsb_first), .start(start),
        .y_out(y_out), .y_done(y_done)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int     xq [NTAP];
    longint m_w [NTAP];
    int     m_st = 0, m_cnt = 0;
    bit     m_lsb = 0;
    longint exp_y = 0;
    bit     exp_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NTAP; j++) xq[j] = 0;
            m_st = 0; exp_y = 0; exp_done = 0;
        end else begin
            exp_done = 0;
            if (m_st == 0) begin
                if (start) begin
                    m_st = 1; m_cnt = 0; m_lsb = lsb_first;
                    for (int j = 0; j < NTAP; j++) m_w[j] = 0;
                end
            end else if (m_st == 1) begin
                int idx;
                idx = m_lsb ? m_cnt : WL - 1 - m_cnt;
                for (int j = 0; j < NTAP; j++) begin
                    if (slice_in[j])
                        m_w[j] += (idx == WL - 1) ? -(longint'(1) << idx) : (longint'(1) << idx);
                end
                m_cnt++;
                if (m_cnt == WL) m_st = 2;
            end else begin
                exp_y = 0;
                for (int j = 0; j < NTAP; j++) exp_y += m_w[j] * xq[j];
                exp_done = 1;
                m_st = 0;
            end
            if (samp_vld) begin
                for (int j = NTAP - 1; j > 0; j--) xq[j] = xq[j-1];
                xq[0] = $signed(samp_in);
            end
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(y_done == exp_done, "R7 done vs model", y_done, exp_done);
            chk(longint'($signed(y_out)) == exp_y, "R3 y_out vs model",
                longint'($signed(y_out)), exp_y);
        end
    end

    task automatic push(input int v);
        @(negedge clk);
        samp_in = DW'(v); samp_vld = 1'b1;
        @(posedge clk);
        #1 samp_vld = 1'b0;
    endtask

    task automatic product(input int w [NTAP], input bit lsb, input bit poke, input string tag);
        longint e;
        e = 0;
        for (int j = 0; j < NTAP; j++) e += longint'(w[j]) * xq[j];
        @(negedge clk);
        start = 1'b1; lsb_first = lsb;
        for (int c = 0; c < WL; c++) begin
            int idx;
            idx = lsb ? c : WL - 1 - c;
            @(negedge clk);
            start = poke && (c == 3);
            lsb_first = ~lsb;
            for (int j = 0; j < NTAP; j++) slice_in[j] = ((w[j] >>> idx) & 1) != 0;
        end
        @(negedge clk);
        start = 1'b0; slice_in = '0;
        @(negedge clk);
        chk(y_done == 1'b1, {tag, " done"}, y_done, 1);
        chk(longint'($signed(y_out)) == e, {tag, " value"}, longint'($signed(y_out)), e);
        @(negedge clk);
        chk(y_done == 1'b0, "R7 single pulse", y_done, 0);
    endtask

    initial begin
        int w [NTAP];
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(y_out == '0, "R10 y_out in reset", y_out, 0);
        chk(y_done == 1'b0, "R10 done in reset", y_done, 0);
        rst_n = 1'b1;
        cmp_on = 1;

        push(10); push(-20); push(30); push(-40);
        w = '{3, -5, 7, 1};
        product(w, 1'b0, 1'b0, "R4 msb-first");
        product(w, 1'b1, 1'b0, "R5 lsb-first");
        w = '{0, 0, 0, 0};
        product(w, 1'b0, 1'b0, "R2 zero slice");
        // R1 / R2: one-hot weights pick each delayed sample
        for (int t = 0; t < NTAP; t++) begin
            w = '{0, 0, 0, 0};
            w[t] = 1;
            product(w, t[0], 1'b0, "R1 R2 tap select");
        end
        // R9: range limits
        for (int j = 0; j < NTAP; j++) push(-128);
        w = '{-128, -128, -128, -128};
        product(w, 1'b0, 1'b0, "R9 max positive");
        product(w, 1'b1, 1'b0, "R9 max positive lsb");
        w = '{127, 127, 127, 127};
        product(w, 1'b0, 1'b0, "R9 max negative");
        // R8: start mid-run ignored
        push(55);
        w = '{-7, 19, 100, -1};
        product(w, 1'b0, 1'b1, "R8 busy start");
        product(w, 1'b1, 1'b1, "R8 busy start lsb");
        // R11: new sample rebuilds the table
        push(-3);
        product(w, 1'b0, 1'b0, "R11 rebuilt table");
        // R3 / R6: mixed patterns
        for (int r = 0; r < 16; r++) begin
            push(int'($urandom_range(0, 255)) - 128);
            for (int j = 0; j < NTAP; j++) w[j] = int'($urandom_range(0, 255)) - 128;
            product(w, r[0], r[1], "R3 R6 mixed");
        end
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule